// File: doc/BRIEF.md
# Packet Length Checker and Gate

This block sits on a 32-bit AXI4-Stream carrying packets whose first word announces the packet length. It counts the words that actually arrive for each packet and compares that count with the announced length. A packet that agrees is passed on. Any other packet is thrown away and reported on a single error line.

Every incoming packet is written into an internal buffer of 2^SIZE words. The packet becomes visible downstream only after its last word has been checked. A rejected packet is removed by moving the write pointer back to where the packet started. The output end-of-packet marker is not copied from the input. It is placed on the word whose position equals the header length. The input is stalled only when the buffer has no free entry. A synchronous clear empties the buffer and abandons any packet that is partly received.

Top module: `pktchk_gate`

## Requirements
- R1: The packet length is bits 15:0 of the first word. It counts 32-bit words, and the header word is one of them. A packet whose word count equals that length leaves the block unchanged, in arrival order relative to other accepted packets.
- R2: On every output word, o_tlast is 1 exactly when the word is the length-th word of its packet, counting the header as word 1.
- R3: A packet whose input tlast arrives before the length-th word (short packet) is dropped entirely.
- R4: A packet that has not ended by its length-th word (long packet) is dropped entirely. Every further input word up to and including the one with input tlast is accepted and discarded.
- R5: A header with a length field of 0 drops the packet.
- R6: A header whose length field is larger than 2^SIZE drops the packet. Its words are accepted and discarded up to input tlast, so the block never waits for buffer space that cannot exist.
- R7: bus_error is high for exactly one cycle for each dropped packet. That cycle is the one after the input word that decides the drop is accepted.
- R8: o_tvalid stays 0 for a packet until its final word has been accepted. With the output idle, o_tvalid rises one cycle after that acceptance.
- R9: Once a released packet begins, o_tvalid stays 1 until its o_tlast word has been transferred. While o_tready is 0, o_tdata and o_tlast hold their values.
- R10: i_tready is 0 only when the buffer holds 2^SIZE words and is not discarding. The buffer never holds more than 2^SIZE words.
- R11: clr empties the buffer, abandons a partly received packet and clears bus_error. The next packet is handled as a fresh header.
- R12: After reset, o_tvalid is 0, bus_error is 0 and i_tready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clr | input | 1 | Synchronous clear, active high |
| i_tdata | input | 32 | Input stream data |
| i_tlast | input | 1 | Input end-of-packet marker |
| i_tvalid | input | 1 | Input data valid |
| i_tready | output | 1 | Block can take an input word |
| o_tdata | output | 32 | Output stream data |
| o_tlast | output | 1 | Output end-of-packet, taken from the header length |
| o_tvalid | output | 1 | Output data valid |
| o_tready | input | 1 | Downstream can take a word |
| bus_error | output | 1 | One-cycle pulse for each dropped packet |

## Verification
Well-formed packets of lengths 1, 2, 3, 5 and exactly 2^SIZE are sent first. They show that data, order and the position of the regenerated end marker survive the buffer. Short, long, zero-length and oversized packets are placed between good ones. A following good packet that arrives intact shows that the rollback and the discard-until-tlast path removed every stray word. An error-pulse check then separates a drop decided on the final word from one decided earlier. Output stalls and a full buffer with the output held off check the hold and back-pressure rules. A clear applied in the middle of a packet must leave no trace on the output.

// File: rtl/pktchk_pkg.sv
package pktchk_pkg;
  // Strobes from the control FSM to the buffer datapath.
  typedef struct packed {
    logic store;    // write the current input word at the write pointer
    logic commit;   // this word closes a good packet: publish it
    logic discard;  // roll the write pointer back to the packet start
  } bufCtl_t;
endpackage

// File: rtl/pktchk_ctrl.sv
module pktchk_ctrl
  import pktchk_pkg::*;
#(
  parameter int SIZE = 5
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        clr,
  input  logic        inValid,
  input  logic        inLast,
  input  logic [15:0] hdrLen,
  input  logic        bufFull,
  output logic        inReady,
  output bufCtl_t     ctl,
  output logic        busErr
);
  localparam int DEPTH = 1 << SIZE;

  typedef enum logic [1:0] {S_HEAD, S_BODY, S_DRAIN} state_t;

  state_t      state, nState;
  logic [15:0] pktLen;
  logic [15:0] wordCnt;
  logic [15:0] nextCnt;
  logic        accept;
  logic        hdrBad;
  logic        dropNow;

  assign inReady = (state == S_DRAIN) || !bufFull;
  assign accept  = inValid && inReady;
  assign hdrBad  = (hdrLen == 16'd0) || (32'(hdrLen) > DEPTH);
  assign nextCnt = wordCnt + 16'd1;

  always_comb begin
    nState  = state;
    ctl     = '0;
    dropNow = 1'b0;
    case (state)
      S_HEAD: if (accept) begin
        ctl.store = 1'b1;
        if (hdrBad) begin
          ctl.discard = 1'b1;
          dropNow     = 1'b1;
          nState      = inLast ? S_HEAD : S_DRAIN;
        end else if (hdrLen == 16'd1) begin
          if (inLast) ctl.commit = 1'b1;
          else begin
            ctl.discard = 1'b1;
            dropNow     = 1'b1;
            nState      = S_DRAIN;
          end
        end else if (inLast) begin
          ctl.discard = 1'b1;
          dropNow     = 1'b1;
        end else begin
          nState = S_BODY;
        end
      end
      S_BODY: if (accept) begin
        ctl.store = 1'b1;
        if (nextCnt == pktLen) begin
          if (inLast) begin
            ctl.commit = 1'b1;
            nState     = S_HEAD;
          end else begin
            ctl.discard = 1'b1;
            dropNow     = 1'b1;
            nState      = S_DRAIN;
          end
        end else if (inLast) begin
          ctl.discard = 1'b1;
          dropNow     = 1'b1;
          nState      = S_HEAD;
        end
      end
      S_DRAIN: if (accept && inLast) nState = S_HEAD;
      default: nState = S_HEAD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      state   <= S_HEAD;
      busErr  <= 1'b0;
      pktLen  <= '0;
      wordCnt <= '0;
    end else begin
      state  <= nState;
      busErr <= dropNow;
      if (accept && state == S_HEAD) begin
        pktLen  <= hdrLen;
        wordCnt <= 16'd1;
      end else if (accept) begin
        wordCnt <= nextCnt;
      end
    end
  end
endmodule

// File: rtl/pktchk_buf.sv
module pktchk_buf
  import pktchk_pkg::*;
#(
  parameter int SIZE = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  bufCtl_t       ctl,
  input  logic [31:0]   inData,
  output logic          bufFull,
  output logic [SIZE:0] fillLevel,
  output logic [31:0]   outData,
  output logic          outLast,
  output logic          outValid,
  input  logic          outReady
);
  localparam int DEPTH = 1 << SIZE;

  logic [32:0]   mem [DEPTH];
  logic [SIZE:0] wrPtr, cmPtr, rdPtr;

  assign fillLevel = wrPtr - rdPtr;
  assign bufFull   = fillLevel == (SIZE+1)'(DEPTH);
  assign outValid  = rdPtr != cmPtr;
  assign {outLast, outData} = mem[rdPtr[SIZE-1:0]];

  always_ff @(posedge clk) begin
    if (ctl.store) mem[wrPtr[SIZE-1:0]] <= {ctl.commit, inData};
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wrPtr <= '0;
      cmPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (ctl.discard)    wrPtr <= cmPtr;
      else if (ctl.store) wrPtr <= wrPtr + 1'b1;
      if (ctl.store && ctl.commit) cmPtr <= wrPtr + 1'b1;
      if (outValid && outReady)    rdPtr <= rdPtr + 1'b1;
    end
  end
endmodule

// File: rtl/pktchk_gate.sv
module pktchk_gate
  import pktchk_pkg::*;
#(
  parameter int SIZE = 5
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        clr,
  input  logic [31:0] i_tdata,
  input  logic        i_tlast,
  input  logic        i_tvalid,
  output logic        i_tready,
  output logic [31:0] o_tdata,
  output logic        o_tlast,
  output logic        o_tvalid,
  input  logic        o_tready,
  output logic        bus_error
);
  bufCtl_t       ctl;
  logic          bufFull;
  logic [SIZE:0] fillLevel;

  pktchk_ctrl #(.SIZE(SIZE)) u_ctrl (
    .clk(clk), .rst(rst), .clr(clr),
    .inValid(i_tvalid), .inLast(i_tlast), .hdrLen(i_tdata[15:0]),
    .bufFull(bufFull), .inReady(i_tready), .ctl(ctl), .busErr(bus_error)
  );

  pktchk_buf #(.SIZE(SIZE)) u_buf (
    .clk(clk), .rst(rst), .clr(clr), .ctl(ctl), .inData(i_tdata),
    .bufFull(bufFull), .fillLevel(fillLevel),
    .outData(o_tdata), .outLast(o_tlast), .outValid(o_tvalid), .outReady(o_tready)
  );
endmodule

// File: rtl/pktchk_sva.sv
module pktchk_sva #(
  parameter int SIZE = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          clr,
  input logic          iValid,
  input logic          iReady,
  input logic          oValid,
  input logic          oReady,
  input logic [31:0]   oData,
  input logic          oLast,
  input logic          busErr,
  input logic [SIZE:0] fillLevel
);
  localparam int DEPTH = 1 << SIZE;

  // R9: a stalled output word holds.
  a_r9_hold_stall: assert property (@(posedge clk) disable iff (rst || clr)
    (oValid && !oReady) |=> (oValid && $stable(oData) && $stable(oLast)));

  // R7: an error pulse always follows an accepted input word.
  a_r7_err_after_accept: assert property (@(posedge clk) disable iff (rst || clr)
    busErr |-> $past(iValid && iReady));

  // R8: output appears only after an input word has been accepted.
  a_r8_visible_after_accept: assert property (@(posedge clk) disable iff (rst || clr)
    $rose(oValid) |-> $past(iValid && iReady));

  // R10: the buffer never holds more than its capacity.
  a_r10_no_overflow: assert property (@(posedge clk) disable iff (rst)
    fillLevel <= (SIZE+1)'(DEPTH));
endmodule

bind pktchk_gate pktchk_sva #(.SIZE(SIZE)) u_sva (
  .clk(clk), .rst(rst), .clr(clr),
  .iValid(i_tvalid), .iReady(i_tready),
  .oValid(o_tvalid), .oReady(o_tready), .oData(o_tdata), .oLast(o_tlast),
  .busErr(bus_error), .fillLevel(fillLevel)
);

// File: tb/test_pktchk_gate.sv
module test_pktchk_gate;
  localparam int SIZE  = 5;
  localparam int DEPTH = 1 << SIZE;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clr = 1'b0;
  logic [31:0] i_tdata = '0;
  logic        i_tlast = 1'b0;
  logic        i_tvalid = 1'b0;
  logic        i_tready;
  logic [31:0] o_tdata;
  logic        o_tlast;
  logic        o_tvalid;
  logic        o_tready = 1'b0;
  logic        bus_error;

  always #5 clk = ~clk;

  pktchk_gate #(.SIZE(SIZE)) i_pktchk_gate (
    .clk(clk), .rst(rst), .clr(clr),
    .i_tdata(i_tdata), .i_tlast(i_tlast), .i_tvalid(i_tvalid), .i_tready(i_tready),
    .o_tdata(o_tdata), .o_tlast(o_tlast), .o_tvalid(o_tvalid), .o_tready(o_tready),
    .bus_error(bus_error)
  );

  logic [32:0] expQ[$];
  int  nChecks = 0, nFails = 0;
  int  expDrops = 0, seenDrops = 0;
  bit  stallOut = 1'b0, bpMode = 1'b0, prevMid = 1'b0, finished = 1'b0;
  int  phase = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  // Drive one word; entered and left at a negedge.
  task automatic putWord(input logic [31:0] d, input logic last);
    bit ok = 1'b0;
    i_tdata = d; i_tlast = last; i_tvalid = 1'b1;
    while (!ok) begin
      #1 ok = i_tready;
      @(negedge clk);
    end
    i_tvalid = 1'b0;
  endtask

  task automatic sendPkt(input int lenField, input int nWords, input bit good, input int tag);
    for (int i = 0; i < nWords; i++) begin
      logic [31:0] d;
      d = (i == 0) ? {tag[15:0], lenField[15:0]} : {tag[7:0], 24'(i)};
      if (good) expQ.push_back({(i == nWords - 1), d});
      putWord(d, i == nWords - 1);
    end
    if (!good) expDrops++;
  endtask

  task automatic errPulse(input string req);
    #1 check(bus_error == 1'b1, req, "drop pulse", 64'(bus_error), 64'd1);
    @(negedge clk);
    #1 check(bus_error == 1'b0, "R7", "pulse one cycle", 64'(bus_error), 64'd0);
    @(negedge clk);
  endtask

  task automatic drain();
    for (int k = 0; k < 3000 && expQ.size() != 0; k++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // Scoreboard monitor.
  initial begin
    forever begin
      @(negedge clk);
      phase++;
      o_tready = !stallOut && !(bpMode && (phase % 5 == 2 || phase % 7 == 0));
      #1;
      if (!rst && !clr) begin
        if (bus_error) seenDrops++;
        if (prevMid) check(o_tvalid, "R9", "no bubble in packet", 64'(o_tvalid), 64'd1);
        if (o_tvalid && o_tready) begin
          if (expQ.size() == 0) begin
            check(1'b0, "R1", "unexpected output word", 64'(o_tdata), 64'd0);
          end else begin
            logic [32:0] e;
            e = expQ.pop_front();
            check(o_tdata == e[31:0], "R1", "data", 64'(o_tdata), 64'(e[31:0]));
            check(o_tlast == e[32], "R2", "tlast from length", 64'(o_tlast), 64'(e[32]));
          end
          prevMid = !o_tlast;
        end
      end
    end
  end

  // Watchdog.
  initial begin
    #2000000;
    if (!finished) begin
      check(1'b0, "R1", "watchdog expired", 64'd0, 64'd1);
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check(o_tvalid == 1'b0, "R12", "o_tvalid after reset", 64'(o_tvalid), 64'd0);
    check(i_tready == 1'b1, "R12", "i_tready after reset", 64'(i_tready), 64'd1);
    check(bus_error == 1'b0, "R12", "bus_error after reset", 64'(bus_error), 64'd0);
    @(negedge clk);

    // Good packets, output free-running.
    sendPkt(1, 1, 1'b1, 1);
    sendPkt(3, 3, 1'b1, 2);
    sendPkt(5, 5, 1'b1, 3);
    // R3 short packet
    sendPkt(4, 2, 1'b0, 4); errPulse("R3");
    sendPkt(2, 2, 1'b1, 5);
    // R4 long packet: pulse came mid-packet, tail is swallowed
    sendPkt(3, 6, 1'b0, 6);
    #1 check(bus_error == 1'b0, "R4", "no second pulse on tail", 64'(bus_error), 64'd0);
    @(negedge clk);
    sendPkt(1, 3, 1'b0, 7);
    sendPkt(3, 3, 1'b1, 8);
    // R5 zero length
    sendPkt(0, 1, 1'b0, 9); errPulse("R5");
    sendPkt(0, 3, 1'b0, 10);
    // R6 oversized
    sendPkt(DEPTH + 3, DEPTH + 3, 1'b0, 11);
    #1 check(i_tready == 1'b1, "R6", "no deadlock after oversize", 64'(i_tready), 64'd1);
    @(negedge clk);
    sendPkt(2, 2, 1'b1, 12);
    drain();

    // Random-ish output back-pressure.
    bpMode = 1'b1;
    for (int n = 0; n < 12; n++) begin
      sendPkt(2 + (n % 6), 2 + (n % 6), 1'b1, 20 + n);
      if (n % 4 == 1) sendPkt(5, 3, 1'b0, 40 + n);
    end
    drain();
    bpMode = 1'b0;

    // R10: fill buffer exactly with output held off.
    stallOut = 1'b1;
    @(negedge clk);
    sendPkt(DEPTH, DEPTH, 1'b1, 50);
    i_tdata = 32'h0033_0002; i_tlast = 1'b0; i_tvalid = 1'b1;
    #1;
    check(i_tready == 1'b0, "R10", "stall when full", 64'(i_tready), 64'd0);
    check(o_tvalid == 1'b1, "R8", "full packet visible", 64'(o_tvalid), 64'd1);
    i_tvalid = 1'b0;
    @(negedge clk);
    stallOut = 1'b0;
    sendPkt(2, 2, 1'b1, 51);
    drain();

    // R8 / R11: partial packet invisible, then cleared.
    putWord(32'h0060_0004, 1'b0);
    putWord(32'h6000_0001, 1'b0);
    #1 check(o_tvalid == 1'b0, "R8", "partial packet hidden", 64'(o_tvalid), 64'd0);
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    #1 check(o_tvalid == 1'b0, "R11", "empty after clear", 64'(o_tvalid), 64'd0);
    @(negedge clk);
    sendPkt(3, 3, 1'b1, 61);
    drain();

    check(expQ.size() == 0, "R1", "all expected words seen", 64'(expQ.size()), 64'd0);
    check(seenDrops == expDrops, "R7", "drop pulse count", 64'(seenDrops), 64'(expDrops));
    finished = 1'b1;
    summary();
  end
endmodule